// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache

This block sits between a processor's fetch port and an external memory port. It keeps recently fetched instruction words and PC-relative data reads in a direct-mapped array. A hit is answered from the array after a single lookup cycle. A miss costs one 32-bit external read, which also fills the line. Ordinary data reads and writes are not allocated. Accesses that target the on-chip RAM window or the on-chip I/O window always go to the external port and never touch the arrays.

Each line is one 32-bit word, which holds two 16-bit instructions. The index comes from address bits [9:2] and selects one of 256 entries. Bits [31:10] form the tag, and each entry has its own valid bit. The tag and data arrays are plain synchronous RAMs. Outside the block, they can be taken from a slice of general on-chip memory while caching is switched on.

Software can start a full invalidation with a one-cycle pulse. Turning caching on also starts one. An invalidation steps through all entries, one per cycle, and holds off the fetch port while it runs. Writes go straight to memory. A write to a word whose line is resident clears that entry, so old code can never be returned.

Top module: `icache_dm`

## Requirements
- R1: After synchronous reset the block holds `cpu_ready` and `mem_req` low, then clears every valid bit over 256 cycles. No request completes during this time, and the first fetch afterwards misses.
- R2: A fetch (`cpu_kind` 2'b00) to a cacheable address that misses issues exactly one external read at the word-aligned address `{addr[31:2],2'b00}`. It returns the data and allocates the line. A repeat fetch of the same word then hits with no external access, and `cpu_ready` rises on the second falling edge after the request is presented.
- R3: PC-relative reads (`cpu_kind` 2'b01) allocate exactly like fetches. Plain data reads (`cpu_kind` 2'b10) always go to the external port and never allocate.
- R4: The index is `addr[9:2]` and the tag is `addr[31:10]`. Two addresses with the same index and different tags evict each other.
- R5: With `cpu_half`=1, the block returns a zero-extended halfword. It returns bits [31:16] when `addr[1]`=0 and bits [15:0] when `addr[1]`=1. With `cpu_half`=0 it returns the whole word.
- R6: Addresses 0xFFFFF000–0xFFFFFFFF (on-chip RAM) and 0xFFFF8000–0xFFFFBFFF (on-chip I/O) always use the external port and never allocate.
- R7: While `cache_en`=0, every access uses the external port and nothing allocates. A rising `cache_en` starts a full invalidation, and the next request waits for it to finish.
- R8: A one-cycle `inv_all` pulse clears every valid bit within 256 cycles, with the fetch port stalled meanwhile. Previously resident lines then miss.
- R9: A write (`cpu_kind` 2'b11) issues one external write carrying the full address and `cpu_wdata`. If that word's line is resident, the entry is invalidated, so the next fetch returns the new value from memory.
- R10: `mem_req` stays high, with `mem_addr` and `mem_we` stable, until `mem_ack` is seen. `cpu_ready` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Caching enable; a rising edge invalidates all entries |
| inv_all | input | 1 | One-cycle pulse requesting a full invalidation |
| cpu_req | input | 1 | Request valid, held until `cpu_ready` |
| cpu_kind | input | 2 | 00 fetch, 01 PC-relative read, 10 data read, 11 write |
| cpu_addr | input | 32 | Byte address |
| cpu_half | input | 1 | 1 = halfword read, 0 = word |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | External request, held until `mem_ack` |
| mem_we | output | 1 | External request is a write |
| mem_addr | output | 32 | External address |
| mem_wdata | output | 32 | External write data |
| mem_ack | input | 1 | External completion, one cycle |
| mem_rdata | input | 32 | External read data, valid with `mem_ack` |

## Verification
Some properties are checked on every cycle:
- The external handshake stays stable while waiting.
- A hit never raises `mem_req`.
- No array write happens during a write access, for a plain data read or for a bypass-window address.
- The port stays silent during an invalidation sweep.

Other behaviour shows only in the bench's scenarios, which compare every access against a reference tag model and a reference memory. This covers whether a given access should have hit, eviction between aliasing tags, and stale code disappearing after a write. It also covers halfword selection, and the fact that enabling caching or pulsing invalidate makes earlier lines miss.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_PCREL = 2'b01,
    ACC_DREAD = 2'b10,
    ACC_WRITE = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    ST_SWEEP,
    ST_IDLE,
    ST_LOOK,
    ST_MEM
  } st_e;
endpackage

// File: rtl/icache_sram.sv
module icache_sram #(
  parameter int W = 32,
  parameter int D = 256,
  localparam int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/icache_region.sv
module icache_region #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RAM_BASE = 32'hFFFF_F000,
  parameter logic [AW-1:0] RAM_MASK = 32'hFFFF_F000,
  parameter logic [AW-1:0] IO_BASE  = 32'hFFFF_8000,
  parameter logic [AW-1:0] IO_MASK  = 32'hFFFF_C000
) (
  input  logic [AW-1:0] addr,
  output logic          bypass
);
  localparam int NR = 2;
  localparam logic [NR-1:0][AW-1:0] BASES = {IO_BASE, RAM_BASE};
  localparam logic [NR-1:0][AW-1:0] MASKS = {IO_MASK, RAM_MASK};

  logic [NR-1:0] in_win;

  for (genvar g = 0; g < NR; g++) begin : g_win
    assign in_win[g] = (addr & MASKS[g]) == BASES[g];
  end

  assign bypass = |in_win;
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SETS = 256,
  parameter logic [AW-1:0] RAM_BASE = 32'hFFFF_F000,
  parameter logic [AW-1:0] RAM_MASK = 32'hFFFF_F000,
  parameter logic [AW-1:0] IO_BASE  = 32'hFFFF_8000,
  parameter logic [AW-1:0] IO_MASK  = 32'hFFFF_C000,
  localparam int OW = $clog2(DW / 8),
  localparam int IW = $clog2(SETS),
  localparam int TW = AW - IW - OW,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cache_en,
  input  logic          inv_all,
  input  logic          cpu_req,
  input  logic [1:0]    cpu_kind,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_half,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic [IW-1:0] rd_idx,
  input  logic [TW:0]   tag_rdata,
  input  logic [DW-1:0] dat_rdata,
  output logic          tag_we,
  output logic [IW-1:0] wr_idx,
  output logic [TW:0]   tag_wdata,
  output logic          dat_we,
  output logic [DW-1:0] dat_wdata
);
  st_e           st;
  logic [AW-1:0] a_q;
  acc_e          k_q;
  logic          h_q;
  logic [DW-1:0] wd_q;
  logic          alloc_q;
  logic [IW-1:0] sweep_cnt;
  logic          en_q;
  logic          inv_pend;
  logic          byp;

  icache_region #(
    .AW(AW), .RAM_BASE(RAM_BASE), .RAM_MASK(RAM_MASK),
    .IO_BASE(IO_BASE), .IO_MASK(IO_MASK)
  ) u_rgn (
    .addr  (a_q),
    .bypass(byp)
  );

  wire [TW-1:0] a_tag = a_q[AW-1 -: TW];
  wire [IW-1:0] a_idx = a_q[OW +: IW];
  wire line_match = tag_rdata[TW] && (tag_rdata[TW-1:0] == a_tag);
  wire cacheable  = cache_en && !byp && (k_q == ACC_FETCH || k_q == ACC_PCREL);
  wire hit        = cacheable && line_match;
  wire wr_inval   = cache_en && !byp && (k_q == ACC_WRITE) && line_match;
  wire inv_start  = inv_pend || inv_all || (cache_en && !en_q);

  assign rd_idx = cpu_addr[OW +: IW];

  function automatic logic [DW-1:0] pick(input logic [DW-1:0] w, input logic half,
                                         input logic upper_sel);
    if (!half) return w;
    return upper_sel ? {{HW{1'b0}}, w[HW-1:0]} : {{HW{1'b0}}, w[DW-1:HW]};
  endfunction

  always_comb begin
    tag_we    = 1'b0;
    wr_idx    = a_idx;
    tag_wdata = {1'b1, a_tag};
    dat_we    = 1'b0;
    dat_wdata = mem_rdata;
    case (st)
      ST_SWEEP: begin
        tag_we    = 1'b1;
        wr_idx    = sweep_cnt;
        tag_wdata = '0;
      end
      ST_LOOK: begin
        if (wr_inval) begin
          tag_we    = 1'b1;
          tag_wdata = '0;
        end
      end
      ST_MEM: begin
        if (mem_ack && alloc_q) begin
          tag_we = 1'b1;
          dat_we = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_SWEEP;
      sweep_cnt <= '0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      a_q       <= '0;
      k_q       <= ACC_FETCH;
      h_q       <= 1'b0;
      wd_q      <= '0;
      alloc_q   <= 1'b0;
      en_q      <= cache_en;
      inv_pend  <= 1'b0;
    end else begin
      cpu_ready <= 1'b0;
      en_q      <= cache_en;
      if (inv_all || (cache_en && !en_q)) inv_pend <= 1'b1;
      case (st)
        ST_SWEEP: begin
          inv_pend  <= 1'b0;
          sweep_cnt <= sweep_cnt + 1'b1;
          if (sweep_cnt == IW'(SETS - 1)) st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (inv_start) begin
            st        <= ST_SWEEP;
            sweep_cnt <= '0;
            inv_pend  <= 1'b0;
          end else if (cpu_req) begin
            a_q  <= cpu_addr;
            k_q  <= acc_e'(cpu_kind);
            h_q  <= cpu_half;
            wd_q <= cpu_wdata;
            st   <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit) begin
            cpu_ready <= 1'b1;
            cpu_rdata <= pick(dat_rdata, h_q, a_q[1]);
            st        <= ST_IDLE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= (k_q == ACC_WRITE);
            mem_addr  <= (k_q == ACC_WRITE) ? a_q : {a_q[AW-1:OW], {OW{1'b0}}};
            mem_wdata <= wd_q;
            alloc_q   <= cacheable;
            st        <= ST_MEM;
          end
        end
        ST_MEM: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            alloc_q   <= 1'b0;
            cpu_ready <= 1'b1;
            cpu_rdata <= mem_we ? '0 : pick(mem_rdata, h_q, a_q[1]);
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R1
  sweep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SWEEP) |-> (!cpu_ready && !mem_req));

  // R2
  hit_nomem_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK && hit) |=> (!mem_req && cpu_ready));

  // R6
  bypass_noalloc_chk: assert property (@(posedge clk) disable iff (rst)
    dat_we |-> !byp);

  // R9
  write_noalloc_chk: assert property (@(posedge clk) disable iff (rst)
    dat_we |-> !mem_we);

  // R3
  dread_noalloc_chk: assert property (@(posedge clk) disable iff (rst)
    dat_we |-> (k_q == ACC_FETCH || k_q == ACC_PCREL));
endmodule

// File: rtl/icache_dm.sv
module icache_dm #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 256,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'hFFFF_F000,
  parameter logic [ADDR_W-1:0] RAM_MASK = 32'hFFFF_F000,
  parameter logic [ADDR_W-1:0] IO_BASE  = 32'hFFFF_8000,
  parameter logic [ADDR_W-1:0] IO_MASK  = 32'hFFFF_C000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cache_en,
  input  logic              inv_all,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_kind,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_half,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OW = $clog2(DATA_W / 8);
  localparam int IW = $clog2(SETS);
  localparam int TW = ADDR_W - IW - OW;

  logic [IW-1:0]     rd_idx, wr_idx;
  logic [TW:0]       tag_rdata, tag_wdata;
  logic [DATA_W-1:0] dat_rdata, dat_wdata;
  logic              tag_we, dat_we;

  icache_ctrl #(
    .AW(ADDR_W), .DW(DATA_W), .SETS(SETS),
    .RAM_BASE(RAM_BASE), .RAM_MASK(RAM_MASK),
    .IO_BASE(IO_BASE), .IO_MASK(IO_MASK)
  ) u_ctrl (
    .clk, .rst, .cache_en, .inv_all,
    .cpu_req, .cpu_kind, .cpu_addr, .cpu_half, .cpu_wdata,
    .cpu_ready, .cpu_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .rd_idx, .tag_rdata, .dat_rdata,
    .tag_we, .wr_idx, .tag_wdata, .dat_we, .dat_wdata
  );

  icache_sram #(.W(TW + 1), .D(SETS)) u_tag (
    .clk, .we(tag_we), .waddr(wr_idx), .wdata(tag_wdata),
    .raddr(rd_idx), .rdata(tag_rdata)
  );

  icache_sram #(.W(DATA_W), .D(SETS)) u_data (
    .clk, .we(dat_we), .waddr(wr_idx), .wdata(dat_wdata),
    .raddr(rd_idx), .rdata(dat_rdata)
  );
endmodule

// File: tb/sim_icache_dm.sv
`timescale 1ns/1ps
module sim_icache_dm;
  logic        clk = 1'b0;
  logic        rst, cache_en, inv_all, cpu_req, cpu_half;
  logic [1:0]  cpu_kind;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata, mem_addr, mem_wdata, mem_rdata;
  logic        cpu_ready, mem_req, mem_we, mem_ack;

  always #5 clk = ~clk;

  icache_dm u0 (.*);

  int vectors = 0, miscompares = 0, nmem = 0, cyc = 0, dly = 0;
  bit done = 0;
  logic [31:0] last_addr, first_addr;
  logic        last_we, waiting = 0;
  logic [31:0] wmem [logic [31:0]];
  bit          mv [256];
  logic [21:0] mt [256];

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    if (wmem.exists(w)) return wmem[w];
    return (w * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic bit in_bypass(input logic [31:0] a);
    return (a >= 32'hFFFF_F000) || (a >= 32'hFFFF_8000 && a <= 32'hFFFF_BFFF);
  endfunction

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // external memory responder, variable latency
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 0; mem_rdata = 0; waiting = 0; dly = 0;
    end else if (mem_ack) begin
      mem_ack = 0;
    end else if (mem_req) begin
      if (!waiting) begin waiting = 1; first_addr = mem_addr; end
      else if (mem_addr != first_addr)
        chk(0, "R10", "mem_addr moved while waiting", mem_addr, first_addr);
      if (dly == 0) begin
        mem_ack = 1;
        mem_rdata = mem_val(mem_addr);
        nmem++;
        last_addr = mem_addr; last_we = mem_we;
        if (mem_we) wmem[{mem_addr[31:2], 2'b00}] = mem_wdata;
        waiting = 0;
        dly = $urandom % 3;
      end else dly--;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 180000);
      summary();
      $finish;
    end
  end

  task automatic model_clear();
    for (int i = 0; i < 256; i++) mv[i] = 0;
  endtask

  task automatic acc(input logic [1:0] k, input logic [31:0] a, input logic h,
                     input logic [31:0] wd, input string r, output int lat,
                     output bit was_hit);
    int n0;
    logic [31:0] w, exp;
    bit byp, cab, hm;
    logic [7:0] idx = a[9:2];
    logic [21:0] tg = a[31:10];
    byp = in_bypass(a);
    cab = cache_en && !byp && (k < 2);
    hm  = cab && mv[idx] && (mt[idx] == tg);
    w   = mem_val(a);
    exp = !h ? w : (a[1] ? {16'h0, w[15:0]} : {16'h0, w[31:16]});
    n0  = nmem;
    @(negedge clk);
    cpu_req = 1; cpu_kind = k; cpu_addr = a; cpu_half = h; cpu_wdata = wd;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ready && lat < 3000);
    cpu_req = 0;
    if (k != 2'b11) chk(cpu_rdata == exp, r, "read data", cpu_rdata, exp);
    chk((nmem - n0) == (hm ? 0 : 1), r, "external access count", nmem - n0, hm ? 0 : 1);
    if (hm) chk(lat == 2, r, "hit latency", lat, 2);
    else begin
      chk(last_addr == ((k == 2'b11) ? a : {a[31:2], 2'b00}), r, "external address",
          last_addr, (k == 2'b11) ? a : {a[31:2], 2'b00});
      chk(last_we == (k == 2'b11), r, "external write flag", last_we, k == 2'b11);
    end
    if (cab && !hm) begin mv[idx] = 1; mt[idx] = tg; end
    if (k == 2'b11 && cache_en && !byp && mv[idx] && mt[idx] == tg) mv[idx] = 0;
    was_hit = hm;
  endtask

  task automatic pulse_inv();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
    model_clear();
  endtask

  initial begin
    int lat;
    bit hh;
    logic [31:0] A = 32'h0000_1234 & 32'hFFFF_FFFC;
    logic [31:0] D = A + 32'h0000_0400;
    logic [31:0] B = 32'h0004_0088, C = 32'h0000_2040;
    void'($urandom(32'd1234));
    rst = 1; cache_en = 1; inv_all = 0; cpu_req = 0; cpu_kind = 0;
    cpu_addr = 0; cpu_half = 0; cpu_wdata = 0;
    model_clear();
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cpu_ready == 0, "R1", "ready in reset", cpu_ready, 0);
    chk(mem_req == 0, "R1", "mem_req in reset", mem_req, 0);
    rst = 0;
    acc(2'b00, A, 0, 0, "R1", lat, hh);
    chk(lat > 256, "R1", "first fetch waits for sweep", lat, 257);
    chk(!hh, "R1", "first fetch misses", hh, 0);
    acc(2'b00, A, 0, 0, "R2", lat, hh);
    chk(hh, "R2", "repeat fetch hits", hh, 1);
    acc(2'b00, A, 1, 0, "R5", lat, hh);
    acc(2'b00, A + 2, 1, 0, "R5", lat, hh);
    acc(2'b01, B, 0, 0, "R3", lat, hh);
    acc(2'b01, B + 2, 1, 0, "R3", lat, hh);
    chk(hh, "R3", "pc-relative read allocated", hh, 1);
    acc(2'b10, C, 0, 0, "R3", lat, hh);
    acc(2'b10, C, 0, 0, "R3", lat, hh);
    chk(!hh, "R3", "data read not allocated", hh, 0);
    acc(2'b00, D, 0, 0, "R4", lat, hh);
    acc(2'b00, A, 0, 0, "R4", lat, hh);
    chk(!hh, "R4", "aliasing tag evicted line", hh, 0);
    acc(2'b00, 32'hFFFF_F010, 0, 0, "R6", lat, hh);
    acc(2'b00, 32'hFFFF_F010, 0, 0, "R6", lat, hh);
    acc(2'b01, 32'hFFFF_8100, 1, 0, "R6", lat, hh);
    acc(2'b01, 32'hFFFF_8100, 1, 0, "R6", lat, hh);
    acc(2'b11, A, 0, 32'hCAFE_F00D, "R9", lat, hh);
    acc(2'b00, A, 0, 0, "R9", lat, hh);
    chk(cpu_rdata == 32'hCAFE_F00D, "R9", "new code visible after write", cpu_rdata, 32'hCAFE_F00D);
    @(negedge clk); cache_en = 0;
    acc(2'b00, B, 0, 0, "R7", lat, hh);
    acc(2'b00, B, 0, 0, "R7", lat, hh);
    @(negedge clk); cache_en = 1; model_clear();
    acc(2'b00, A, 0, 0, "R7", lat, hh);
    chk(lat > 256 && !hh, "R7", "enable rise invalidates", lat, 257);
    acc(2'b00, A, 0, 0, "R8", lat, hh);
    pulse_inv();
    acc(2'b00, A, 0, 0, "R8", lat, hh);
    chk(lat > 256 && lat < 280 && !hh, "R8", "invalidate stall and miss", lat, 260);
    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 20;
      logic [21:0] tg;
      logic [7:0] ix;
      logic [1:0] k;
      case ($urandom % 5)
        0: tg = 22'h000; 1: tg = 22'h001; 2: tg = 22'h2A5;
        3: tg = 22'h3FFFFF; default: tg = 22'h3FFFE0;
      endcase
      ix = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 8);
      if (r == 19) begin pulse_inv(); continue; end
      k = (r < 10) ? 2'b00 : (r < 14) ? 2'b01 : (r < 16) ? 2'b10 : 2'b11;
      acc(k, {tg, ix, 1'b0, 1'($urandom % 2), 1'b0}, 1'($urandom % 2), $urandom,
          "R2", lat, hh);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule